// File: doc/BRIEF.md
# Multi-Format Audio Capture Serializer

This block takes parallel audio samples for up to six capture channels and shifts them out on one serial data line. It follows a bit clock and a frame clock that come from elsewhere in the same clock domain. It supports three framings: two-channel I2S, two-channel left-justified, and a time-division-multiplexed (TDM) mode. In TDM mode a 256-bit frame carries a contiguous block of 2, 4 or 6 slots, and that block starts at a programmable bit offset from a one-bit frame pulse.

Both clocks are sampled by the system clock `clk`. Each falling edge of the bit clock is one bit event, and the serial line changes only after a bit event. Clock polarity is fixed: the bit clock and the frame clock are never inverted.

Samples arrive on a wide bus with a valid strobe, and the block holds the most recent valid set. At the first bit of each frame's data block, the held set is copied into the shifting copy, and `smp_req` pulses to ask for the next set. If no new valid set has arrived, the same samples go out again.

There are two TDM variants. With `fmt` = 2 the slots start at the offset itself. With `fmt` = 3 they start one bit clock later. To place data in the slot of index n, set the offset to n times the word length. Active slots are always contiguous.

Top module: `audio_capture_serializer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sdo` and `smp_req` are 0.
- R2: `wl_sel` chooses the word length for every channel: 0 selects 16 bits, 1 selects 20, 2 selects 24 and 3 selects 32. Channel k occupies `smp_data[32k+31:32k]`, and its MSB is bit 31 of that lane. Each word is sent MSB first, with only word-length bits per channel.
- R3: When `fmt` = 0 (I2S), a falling `fclk` seen at a bit event marks the frame. The left word (channel 0) starts one bit event later, and the right word (channel 1) follows it directly. The frame is 2 times word-length bit clocks, so the right word's LSB falls on the next marker.
- R4: When `fmt` = 1 (left-justified), a rising `fclk` seen at a bit event marks the frame, and the left word's MSB goes out at that same bit event. The right word follows directly.
- R5: When `fmt` = 2 or 3 (TDM), a rising `fclk` marks a 256-bit frame. The slot block starts `tdm_off` (0 to 255) bit events after the marker, plus one more when `fmt` = 3. If the block runs past the frame end, it continues into the next frame until its last bit. If the start point lies at 256 or beyond, that frame carries no block.
- R6: In TDM mode, `tdm_ch` 0 sends channels 0 to 1, 1 sends channels 0 to 3, and 2 or 3 sends channels 0 to 5. The slots are back to back, each one word length wide.
- R7: At every bit event outside a data block, `sdo` is 0.
- R8: Data on `smp_data` with `smp_valid` low is ignored. A block with no new valid set since the previous block repeats the previous samples.
- R9: `smp_req` is a single-clock pulse at the first bit event of each data block. It pulses exactly once per frame whenever the block starts inside the frame.
- R10: `sdo` changes only on the clock after a bit event (a falling `bclk`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bit and frame clocks are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock; its falling edge is a bit event |
| fclk | input | 1 | Frame clock or frame pulse |
| fmt | input | 2 | 0 I2S, 1 left-justified, 2 TDM, 3 TDM delayed by one bit |
| wl_sel | input | 2 | Word length code (16/20/24/32) |
| tdm_ch | input | 2 | TDM channel count code (2/4/6) |
| tdm_off | input | 8 | TDM block offset in bit clocks |
| smp_data | input | NCH*LANE | Sample lanes, channel 0 in the low lane |
| smp_valid | input | 1 | Captures `smp_data` into the held set |
| sdo | output | 1 | Serial data, MSB first |
| smp_req | output | 1 | One-clock pulse when a new block starts |

## Verification
A wrong internal state shows up on `sdo` at the next bit event. A bad slot or bit counter shifts a whole block, and a bad offset countdown moves its start point. Both therefore appear within one frame as a mismatch against the expected stream, bit by bit.

The bench compares a whole steady-state frame against a stream computed from the formula in each requirement. A stale or early copy of the samples appears in the frame after the copy should have happened. A missing or doubled start appears as a wrong `smp_req` count within that same frame.

// File: rtl/audio_capture_serializer.sv
module audio_capture_serializer #(
  parameter int NCH  = 6,
  parameter int LANE = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bclk,
  input  logic                  fclk,
  input  logic [1:0]            fmt,
  input  logic [1:0]            wl_sel,
  input  logic [1:0]            tdm_ch,
  input  logic [7:0]            tdm_off,
  input  logic [NCH*LANE-1:0]   smp_data,
  input  logic                  smp_valid,
  output logic                  sdo,
  output logic                  smp_req
);
  localparam int CW = $clog2(NCH);
  localparam int IW = $clog2(NCH*LANE);
  localparam logic [1:0] F_I2S = 2'd0, F_LJ = 2'd1, F_TDMB = 2'd2, F_TDMA = 2'd3;

  logic                bq, fprev, run, dly_run;
  logic [8:0]          dly, lead;
  logic [CW-1:0]       slot, s_cur;
  logic [5:0]          bitc, b_cur, wl;
  logic [CW:0]         nch;
  logic [NCH*LANE-1:0] pend, lat, src;
  logic                fall, mark, start, active, last_bit, last_slot;
  logic [IW-1:0]       idx;

  always_comb begin
    case (wl_sel)
      2'd0:    wl = 6'd16;
      2'd1:    wl = 6'd20;
      2'd2:    wl = 6'd24;
      default: wl = 6'd32;
    endcase
    if (fmt == F_I2S || fmt == F_LJ) nch = (CW+1)'(2);
    else if (tdm_ch == 2'd0)         nch = (CW+1)'(2);
    else if (tdm_ch == 2'd1)         nch = (CW+1)'(4);
    else                             nch = (CW+1)'(6);
    case (fmt)
      F_I2S:   lead = 9'd1;
      F_LJ:    lead = 9'd0;
      F_TDMB:  lead = {1'b0, tdm_off};
      default: lead = {1'b0, tdm_off} + 9'd1;
    endcase
  end

  assign fall   = bq & ~bclk;
  assign mark   = fall & ((fmt == F_I2S) ? (fprev & ~fclk) : (~fprev & fclk));
  assign start  = mark ? (lead == 9'd0) : (fall & dly_run & (dly == 9'd1));
  assign active = start | (fall & run);
  assign s_cur  = start ? '0 : slot;
  assign b_cur  = start ? '0 : bitc;
  assign src    = start ? pend : lat;
  assign idx    = IW'(s_cur) * IW'(LANE) + IW'(LANE-1) - IW'(b_cur);
  assign last_bit  = (b_cur + 6'd1) >= wl;
  assign last_slot = ({1'b0, s_cur} + (CW+1)'(1)) >= nch;

  always_ff @(posedge clk) begin
    if (rst) begin
      bq <= 1'b0; fprev <= 1'b0; run <= 1'b0; dly_run <= 1'b0; dly <= '0;
      slot <= '0; bitc <= '0; pend <= '0; lat <= '0; sdo <= 1'b0; smp_req <= 1'b0;
    end else begin
      bq      <= bclk;
      smp_req <= start;
      if (smp_valid) pend <= smp_data;
      if (fall) begin
        fprev <= fclk;
        sdo   <= active ? src[idx] : 1'b0;
        if (start) lat <= pend;
        if (mark && lead != 9'd0) begin
          dly     <= lead;
          dly_run <= 1'b1;
        end else if (start) begin
          dly_run <= 1'b0;
        end else if (dly_run) begin
          dly <= dly - 9'd1;
        end
        if (active) begin
          if (last_bit) begin
            bitc <= '0;
            slot <= s_cur + CW'(1);
            run  <= ~last_slot;
          end else begin
            bitc <= b_cur + 6'd1;
            slot <= s_cur;
            run  <= 1'b1;
          end
        end
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (sdo == 1'b0 && !smp_req));
  p_sdo_on_fall_r10: assert property (@(posedge clk) disable iff (rst) !fall |=> $stable(sdo));
  p_req_single_r9: assert property (@(posedge clk) disable iff (rst) smp_req |=> !smp_req);
  p_slot_bound_r6: assert property (@(posedge clk) disable iff (rst) run |-> (slot < CW'(NCH)));
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst) (fall && !run && !start) |=> (sdo == 1'b0));
endmodule

// File: tb/tb_audio_capture_serializer.sv
module tb_audio_capture_serializer;
  logic clk = 1'b0;
  logic rst, bclk, fclk, smp_valid;
  logic [1:0] fmt, wl_sel, tdm_ch;
  logic [7:0] tdm_off;
  logic [191:0] smp_data;
  logic sdo, smp_req;
  int checks = 0, errors = 0, reqcnt = 0, seed = 1;
  logic cap [0:255];

  always #2 clk = ~clk;

  audio_capture_serializer dut (
    .clk(clk), .rst(rst), .bclk(bclk), .fclk(fclk), .fmt(fmt), .wl_sel(wl_sel),
    .tdm_ch(tdm_ch), .tdm_off(tdm_off), .smp_data(smp_data), .smp_valid(smp_valid),
    .sdo(sdo), .smp_req(smp_req));

  always @(negedge clk) if (!rst && smp_req) reqcnt = reqcnt + 1;

  function automatic logic [191:0] mk(int s);
    logic [191:0] v;
    for (int c = 0; c < 6; c++) v[c*32 +: 32] = (32'h9E3779B9 * (s*8 + c + 1)) ^ 32'hA5C3_1E87;
    return v;
  endfunction

  function automatic logic expb(int p, int len, int lead, int wl, int nch,
                                logic [191:0] cur, logic [191:0] prev);
    int d; logic [191:0] s;
    d = p - lead; s = cur;
    if (d < 0) begin
      if (lead >= len) return 1'b0;
      d = p + len - lead; s = prev;
    end
    if (d >= nch*wl) return 1'b0;
    return s[(d/wl)*32 + 31 - (d%wl)];
  endfunction

  task automatic tick(input logic f, input int p);
    @(negedge clk); bclk = 1'b0; fclk = f;
    @(negedge clk); cap[p] = sdo;
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame(input int fm, input int len, input int wl);
    for (int p = 0; p < len; p++) begin
      if (fm == 0)      tick(p >= wl, p);
      else if (fm == 1) tick(p < wl, p);
      else              tick(p == 0, p);
    end
  endtask

  task automatic load(input logic [191:0] v);
    @(negedge clk); smp_data = v; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic check_frame(input string tag, input int len, input int lead, input int wl,
                             input int nch, input logic [191:0] cur, input logic [191:0] prev);
    int bad; logic e;
    bad = -1; e = 1'b0;
    for (int p = 0; p < len; p++)
      if (bad < 0 && cap[p] !== expb(p, len, lead, wl, nch, cur, prev)) begin
        bad = p; e = expb(p, len, lead, wl, nch, cur, prev);
      end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: bit %0d actual=%0b expected=%0b (fmt=%0d wl=%0d nch=%0d lead=%0d)",
               tag, bad, cap[bad], e, fmt, wl, nch, lead);
    end
  endtask

  task automatic run_cfg(input int fm, input int wc, input int cc, input int off,
                         input int nfr, input string tag);
    int wl, nch, lead, len, r0;
    logic [191:0] s;
    wl   = (wc == 3) ? 32 : 16 + 4*wc;
    nch  = (fm < 2) ? 2 : (cc == 0 ? 2 : (cc == 1 ? 4 : 6));
    lead = (fm == 0) ? 1 : (fm == 1 ? 0 : off + (fm == 3 ? 1 : 0));
    len  = (fm < 2) ? 2*wl : 256;
    @(negedge clk); fmt = 2'(fm); wl_sel = 2'(wc); tdm_ch = 2'(cc); tdm_off = 8'(off);
    s = mk(seed); seed++;
    load(s);
    r0 = 0;
    for (int f = 0; f < nfr; f++) begin
      r0 = reqcnt;
      frame(fm, len, wl);
    end
    check_frame(tag, len, lead, wl, nch, s, s);
    checks++;
    if ((reqcnt - r0) != ((lead < len) ? 1 : 0)) begin
      errors++;
      $display("FAIL R9: request pulses in frame actual=%0d expected=%0d", reqcnt - r0, (lead < len) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: R1..R10 run incomplete actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [191:0] a, b;
    rst = 1'b1; bclk = 1'b1; fclk = 1'b0; smp_valid = 1'b0; smp_data = '0;
    fmt = '0; wl_sel = '0; tdm_ch = '0; tdm_off = '0;
    repeat (5) @(negedge clk);
    checks++;
    if (sdo !== 1'b0 || smp_req !== 1'b0) begin
      errors++; $display("FAIL R1: in reset actual=%0b%0b expected=00", sdo, smp_req);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (sdo !== 1'b0 || smp_req !== 1'b0) begin
      errors++; $display("FAIL R1: after reset actual=%0b%0b expected=00", sdo, smp_req);
    end
    for (int fm = 2; fm < 4; fm++)
      for (int wc = 0; wc < 4; wc++)
        for (int cc = 0; cc < 3; cc++)
          for (int oi = 0; oi < 2; oi++)
            run_cfg(fm, wc, cc, oi * 37, 2, "R2 R5 R6 R7 R8");
    run_cfg(2, 0, 0, 255, 2, "R5 R7 boundary offset");
    run_cfg(3, 0, 0, 255, 2, "R5 R7 block beyond frame");
    for (int wc = 0; wc < 4; wc++) run_cfg(1, wc, 0, 0, 3, "R2 R4 R7");
    for (int wc = 0; wc < 4; wc++) run_cfg(0, wc, 0, 0, 3, "R2 R3 R7");
    @(negedge clk); fmt = 2'd1; wl_sel = 2'd0;
    a = mk(900); b = mk(901);
    load(a);
    frame(1, 32, 16); frame(1, 32, 16);
    check_frame("R8 repeat held set", 32, 0, 16, 2, a, a);
    @(negedge clk); smp_data = b;
    frame(1, 32, 16);
    check_frame("R8 data without valid ignored", 32, 0, 16, 2, a, a);
    load(b);
    frame(1, 32, 16);
    check_frame("R8 new valid set taken", 32, 0, 16, 2, b, a);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule